// File: doc/BRIEF.md
# Configurable UART Character Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. The bit rate comes from a one-cycle baud tick pulse, which a baud-rate generator shared with the receiver produces. The frame format is chosen at runtime from a set of format inputs:
- 7 or 8 data bits
- no parity, even parity or odd parity
- an optional address/data marker bit
- one or two stop bits
- data sent least-significant or most-significant bit first

A character is offered on a valid/ready load port. The format inputs are captured together with the character, so a frame is never disturbed by a later change of format. A software-reset input abandons any frame in progress and holds the block idle. A transmit interrupt enable and an interrupt output signal the host when the block can take another character.

Top module: `uart_char_tx`

## Requirements
- R1: After `rst` the line `txd` is at mark (1), `ld_ready` is 1 and `tx_ie` is 0. The line stays at mark whenever no frame is being sent.
- R2: A frame opens with one start bit of value 0. Every bit, start bit included, begins at a cycle where `baud_tick` is high and lasts until the next such cycle. The first bit begins at the first tick after the cycle in which the character was accepted.
- R3: With `fmt_eight_bits`=1 the eight data bits `ld_data[7:0]` are sent. With `fmt_eight_bits`=0 only `ld_data[6:0]` are sent, and bit 7 is left out of the frame.
- R4: With `fmt_msb_first`=0 the data go out lowest index first. With `fmt_msb_first`=1 they go out highest sent index first, so in 7-bit mode bit 6 leads.
- R5: With `fmt_parity_en`=1 one parity bit follows the data. Its value is the XOR of the data bits actually sent, inverted when `fmt_parity_odd`=1. With `fmt_parity_en`=0 there is no parity slot.
- R6: With `fmt_addr_mode`=1 one extra bit equal to `fmt_addr_flag` follows the parity position (address 1, data 0). This bit never enters the parity.
- R7: The frame closes with one stop bit of value 1, or two when `fmt_two_stop`=1.
- R8: `ld_ready` falls in the cycle after a load is accepted and rises only at the tick that ends the last stop bit. Loads offered while `ld_ready` is 0 are ignored.
- R9: While `sw_reset` is 1, `ld_ready` is forced to 1, `tx_ie` is cleared, `txd` is at mark, any frame in progress is dropped and loads are ignored.
- R10: `ie_wr` writes `ie_wdata` into `tx_ie`. `tx_irq` is 1 exactly when `tx_ie` and `ld_ready` are both 1.
- R11: Data and format are sampled in the accepting cycle. Changes to them during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_reset | input | 1 | Software reset, held high to keep the block idle |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| ld_valid | input | 1 | Character offered |
| ld_data | input | 8 | Character to send |
| ld_ready | output | 1 | Block can accept a character (transmit flag) |
| fmt_eight_bits | input | 1 | 1: eight data bits, 0: seven |
| fmt_parity_en | input | 1 | Parity bit present |
| fmt_parity_odd | input | 1 | 1: odd parity, 0: even parity |
| fmt_addr_mode | input | 1 | Address marker bit present |
| fmt_addr_flag | input | 1 | Value of the address marker bit |
| fmt_two_stop | input | 1 | 1: two stop bits |
| fmt_msb_first | input | 1 | 1: most significant data bit first |
| ie_wr | input | 1 | Write strobe for the interrupt enable |
| ie_wdata | input | 1 | Value written into the interrupt enable |
| tx_ie | output | 1 | Transmit interrupt enable |
| tx_irq | output | 1 | Transmit interrupt request |
| txd | output | 1 | Serial output line |

## Verification
The assertions check several properties on every cycle:
- the line sits at mark whenever the block reports ready;
- `txd` only moves at a tick or under software reset;
- a load drops ready;
- ready cannot rise without a tick or a software reset;
- software reset forces the flag, the enable and the line to their idle values.

The bit content of a frame needs a reference model, so only the bench's scenarios can show it. That covers data length, bit order, parity polarity, the address bit, the stop count and immunity to format changes in mid-frame. The bench therefore sweeps every combination of the seven format inputs with several characters. It also covers abort by software reset and the interrupt gating.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef struct packed {
    logic eight;
    logic par_en;
    logic par_odd;
    logic addr_mode;
    logic addr_flag;
    logic two_stop;
    logic msb_first;
  } tx_fmt_t;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARMED = 2'd1,
    TX_SEND  = 2'd2
  } tx_state_t;

endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              full_len,
  input  logic              odd,
  output logic              par
);
  logic [DATA_W-1:0] mask;

  // the top data bit is dropped in short mode, so it must not count
  assign mask = full_len ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};
  assign par  = (^(data & mask)) ^ odd;
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 5,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  tx_fmt_t            fmt,
  input  logic               par,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   len
);
  logic [DATA_W-1:0] ord_full;
  logic [DATA_W-1:0] ord_short;
  logic [DATA_W-1:0] ordered;

  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_rev_full
      assign ord_full[g] = data[DATA_W-1-g];
    end
    for (g = 0; g < DATA_W - 1; g++) begin : g_rev_short
      assign ord_short[g] = data[DATA_W-2-g];
    end
  endgenerate
  assign ord_short[DATA_W-1] = 1'b0;

  assign ordered = fmt.msb_first ? (fmt.eight ? ord_full : ord_short) : data;

  always_comb begin
    int pos;
    int nbits;
    nbits = fmt.eight ? DATA_W : DATA_W - 1;
    frame = {FRAME_W{1'b1}};
    frame[0] = 1'b0;
    pos = 1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nbits) begin
        frame[pos] = ordered[i];
        pos = pos + 1;
      end
    end
    if (fmt.par_en) begin
      frame[pos] = par;
      pos = pos + 1;
    end
    if (fmt.addr_mode) begin
      frame[pos] = fmt.addr_flag;
      pos = pos + 1;
    end
    // stop bits are already 1 from the fill above
    len = CNT_W'(pos + (fmt.two_stop ? 2 : 1));
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int FRAME_W = 13,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_reset,
  input  logic               baud_tick,
  input  logic               ld_valid,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   len,
  output logic               ld_ready,
  output logic               txd
);
  tx_state_t          state;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   remain;

  always_ff @(posedge clk) begin
    if (rst || sw_reset) begin
      state    <= TX_IDLE;
      shreg    <= {FRAME_W{1'b1}};
      remain   <= '0;
      txd      <= 1'b1;
      ld_ready <= 1'b1;
    end else begin
      case (state)
        TX_IDLE: begin
          if (ld_valid) begin
            shreg    <= frame;
            remain   <= len;
            state    <= TX_ARMED;
            ld_ready <= 1'b0;
          end
        end
        TX_ARMED: begin
          if (baud_tick) begin
            txd    <= shreg[0];
            shreg  <= {1'b1, shreg[FRAME_W-1:1]};
            remain <= remain - 1'b1;
            state  <= TX_SEND;
          end
        end
        TX_SEND: begin
          if (baud_tick) begin
            if (remain == '0) begin
              txd      <= 1'b1;
              ld_ready <= 1'b1;
              state    <= TX_IDLE;
            end else begin
              txd    <= shreg[0];
              shreg  <= {1'b1, shreg[FRAME_W-1:1]};
              remain <= remain - 1'b1;
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_char_tx.sv
module uart_char_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_reset,
  input  logic              baud_tick,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  output logic              ld_ready,
  input  logic              fmt_eight_bits,
  input  logic              fmt_parity_en,
  input  logic              fmt_parity_odd,
  input  logic              fmt_addr_mode,
  input  logic              fmt_addr_flag,
  input  logic              fmt_two_stop,
  input  logic              fmt_msb_first,
  input  logic              ie_wr,
  input  logic              ie_wdata,
  output logic              tx_ie,
  output logic              tx_irq,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 5;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  tx_fmt_t            fmt;
  logic               par;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;

  assign fmt = '{eight:     fmt_eight_bits,
                 par_en:    fmt_parity_en,
                 par_odd:   fmt_parity_odd,
                 addr_mode: fmt_addr_mode,
                 addr_flag: fmt_addr_flag,
                 two_stop:  fmt_two_stop,
                 msb_first: fmt_msb_first};

  uart_tx_parity #(.DATA_W(DATA_W)) u_par (
    .data     (ld_data),
    .full_len (fmt.eight),
    .odd      (fmt.par_odd),
    .par      (par)
  );

  uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frm (
    .data  (ld_data),
    .fmt   (fmt),
    .par   (par),
    .frame (frame),
    .len   (len)
  );

  uart_tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shf (
    .clk       (clk),
    .rst       (rst),
    .sw_reset  (sw_reset),
    .baud_tick (baud_tick),
    .ld_valid  (ld_valid),
    .frame     (frame),
    .len       (len),
    .ld_ready  (ld_ready),
    .txd       (txd)
  );

  always_ff @(posedge clk) begin
    if (rst || sw_reset) tx_ie <= 1'b0;
    else if (ie_wr)      tx_ie <= ie_wdata;
  end

  assign tx_irq = tx_ie & ld_ready;
endmodule

// File: rtl/uart_char_tx_chk.sv
module uart_char_tx_chk (
  input logic clk,
  input logic rst,
  input logic sw_reset,
  input logic baud_tick,
  input logic ld_valid,
  input logic ld_ready,
  input logic tx_ie,
  input logic txd
);
  p_idle_mark_r1: assert property (@(posedge clk) disable iff (rst)
    ld_ready |-> txd);

  p_bit_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!baud_tick && !sw_reset) |=> $stable(txd));

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready && !sw_reset) |=> !ld_ready);

  p_ready_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
    (!ld_ready && !baud_tick && !sw_reset) |=> !ld_ready);

  p_swreset_idle_r9: assert property (@(posedge clk) disable iff (rst)
    sw_reset |=> (ld_ready && txd && !tx_ie));
endmodule

bind uart_char_tx uart_char_tx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sw_reset  (sw_reset),
  .baud_tick (baud_tick),
  .ld_valid  (ld_valid),
  .ld_ready  (ld_ready),
  .tx_ie     (tx_ie),
  .txd       (txd)
);

// File: tb/uart_char_tx_bench.sv
`timescale 1ns/1ps
module uart_char_tx_bench;
  localparam int TP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_reset = 1'b0;
  logic baud_tick = 1'b0;
  logic ld_valid = 1'b0;
  logic [7:0] ld_data = 8'h00;
  logic ld_ready;
  logic [6:0] cfg = 7'd0;
  logic ie_wr = 1'b0;
  logic ie_wdata = 1'b0;
  logic tx_ie, tx_irq, txd;
  int n_chk = 0;
  int n_bad = 0;
  int tcnt = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt == TP - 1) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == TP - 1);
  end

  // cfg bits: 0 eight, 1 parity en, 2 odd, 3 addr mode, 4 addr flag, 5 two stop, 6 msb first
  uart_char_tx u_uart_char_tx (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .baud_tick(baud_tick),
    .ld_valid(ld_valid), .ld_data(ld_data), .ld_ready(ld_ready),
    .fmt_eight_bits(cfg[0]), .fmt_parity_en(cfg[1]), .fmt_parity_odd(cfg[2]),
    .fmt_addr_mode(cfg[3]), .fmt_addr_flag(cfg[4]), .fmt_two_stop(cfg[5]),
    .fmt_msb_first(cfg[6]), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .tx_ie(tx_ie), .tx_irq(tx_irq), .txd(txd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic void expect_frame(input logic [7:0] d, input logic [6:0] c,
                                       output logic [15:0] v, output int n);
    int nb;
    logic [7:0] dd;
    logic par;
    nb = c[0] ? 8 : 7;
    dd = c[0] ? d : (d & 8'h7F);
    par = (^dd) ^ c[2];
    v = 16'hFFFF;
    v[0] = 1'b0;
    n = 1;
    for (int i = 0; i < nb; i++) begin
      v[n] = c[6] ? dd[nb - 1 - i] : dd[i];
      n++;
    end
    if (c[1]) begin v[n] = par; n++; end
    if (c[3]) begin v[n] = c[4]; n++; end
    n = n + (c[5] ? 2 : 1);
  endfunction

  task automatic send(input logic [7:0] d, input logic [6:0] c);
    logic [15:0] ev, got, mask;
    int en, k;
    bit hold_ok, ready_ok, tk;
    expect_frame(d, c, ev, en);
    @(negedge clk);
    while (!ld_ready) @(negedge clk);
    ld_data = d; cfg = c; ld_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // junk load while busy and changed format (R8, R11)
    ld_data = ~d; cfg = ~c;
    chk(!ld_ready, "R8 ready drop", ld_ready, 0);
    chk(tx_irq == 1'b0, "R10 irq while busy", tx_irq, 0);
    got = 16'hFFFF; k = 0; hold_ok = 1; ready_ok = 1;
    while (k <= en) begin
      @(posedge clk);
      tk = baud_tick;
      @(negedge clk);
      ld_valid = 1'b0;
      if (tk) begin
        if (k < en) got[k] = txd;
        k++;
      end else if (k == 0) begin
        if (txd !== 1'b1) hold_ok = 0;
      end else if (txd !== got[k-1]) hold_ok = 0;
      if (k <= en && ld_ready) ready_ok = 0;
    end
    mask = (16'h1 << en) - 16'h1;
    chk((got & mask) == (ev & mask), "R2 R3 R4 R5 R6 R7 R11 frame", got & mask, ev & mask);
    chk(hold_ok, "R2 bit hold", hold_ok, 1);
    chk(ready_ok, "R8 ready low in frame", ready_ok, 1);
    chk(ld_ready && txd, "R8 R1 ready/mark after stop", {ld_ready, txd}, 2'b11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ld_ready && txd && !tx_ie && !tx_irq, "R1 reset state",
        {ld_ready, txd, tx_ie, tx_irq}, 4'b1100);

    ie_wr = 1'b1; ie_wdata = 1'b1;
    @(negedge clk);
    ie_wr = 1'b0;
    chk(tx_ie && tx_irq, "R10 enable and irq", {tx_ie, tx_irq}, 2'b11);

    for (int c = 0; c < 128; c++) begin
      send(8'hA5, 7'(c));
      send(8'h3C ^ 8'(c * 37), 7'(c));
      send(8'h80 | 8'(c), 7'(c));
    end

    // software reset in the middle of a frame
    @(negedge clk);
    ld_data = 8'h00; cfg = 7'h01; ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    repeat (3 * TP) @(negedge clk);
    sw_reset = 1'b1; ld_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(ld_ready && txd && !tx_ie && !tx_irq, "R9 held reset",
          {ld_ready, txd, tx_ie, tx_irq}, 4'b1100);
    end
    sw_reset = 1'b0; ld_valid = 1'b0;
    begin
      bit quiet = 1;
      repeat (4 * TP) begin
        @(negedge clk);
        if (!(txd && ld_ready)) quiet = 0;
      end
      chk(quiet, "R9 frame dropped, load ignored", quiet, 1);
    end
    send(8'h5A, 7'h7F);
    finish_run();
  end
endmodule